// File: doc/BRIEF.md
# Interrupt Arbiter and Exception Vector Unit

This block decides, on every clock edge, whether the processor enters privileged firmware mode, and if so at which address. It collects four level-sensitive interrupt requests (device, clock, inter-processor and machine check). It masks them against a 3-bit interrupt priority level and picks the most urgent survivor. A synchronous exception request carrying a cause code, including a firmware call with its own 8-bit call number, is also accepted. It wins over any interrupt in the same cycle.

On entry the block registers four things: the new program counter (the firmware base plus a per-cause offset), the saved return address, the raised firmware-mode flag and a one-cycle taken pulse with the chosen cause. Interrupts are never accepted while the firmware-mode input is already high, but exceptions are. The surrounding pipeline owns updating the priority level and returning from firmware mode. It feeds the current values back in each cycle.

Top module: `trap_vector_unit`

## Requirements
- R1: After reset `taken`, `takenCause`, `newPc`, `savedPc` and `modeOut` are all zero.
- R2: An interrupt source is eligible only when `ipl` does not exceed its ceiling: device up to 3, clock up to 4, inter-processor up to 5, machine check up to 6; at level 7 no interrupt is taken.
- R3: Among eligible interrupts the winner is machine check, else inter-processor, else clock, else device, reported in `takenCause` as 1, 2, 3 and 4 respectively.
- R4: While `fwMode` is high no interrupt is taken, while an exception request is still accepted.
- R5: A valid exception request in the same cycle as eligible interrupts is taken instead of them, and its code is reported in `takenCause`.
- R6: For cause codes 0 to 9 (0 reset, 5 memory fault, 6 unaligned access, 7 illegal opcode, 8 arithmetic, 9 floating point disabled, plus the interrupt codes of R3) the vector offset is the code times 0x80.
- R7: Cause code 10 is a firmware call: if bit 7 of `callCode` is set the offset is 0x2000 + (callCode − 0x80) × 64, otherwise 0x1000 + callCode × 64.
- R8: On entry `savedPc` is `pc` with bit 0 replaced by the `fwMode` value sampled at that edge.
- R9: On entry `newPc` equals `fwBase` plus the offset and `modeOut` is 1; in a cycle without entry `modeOut` takes the sampled `fwMode` while `newPc` and `savedPc` hold.
- R10: `taken` is high for exactly the cycle after each accepted edge and low after an edge with nothing accepted.
- R11: An exception request with a code of 11 to 15 is treated as no request; interrupt arbitration proceeds as if it were absent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| irqDev | input | 1 | Device interrupt request |
| irqClk | input | 1 | Clock interrupt request |
| irqIpi | input | 1 | Inter-processor interrupt request |
| irqMchk | input | 1 | Machine-check interrupt request |
| ipl | input | 3 | Current interrupt priority level |
| excReq | input | 1 | Synchronous exception request |
| excCode | input | 4 | Exception cause code (R6, R7, R11) |
| callCode | input | 8 | Firmware call number, used with cause 10 |
| pc | input | 64 | Current program counter |
| fwBase | input | 64 | Firmware base address |
| fwMode | input | 1 | Firmware mode currently active |
| newPc | output | 64 | Entry address after a taken event |
| savedPc | output | 64 | Saved return address with mode in bit 0 |
| modeOut | output | 1 | Updated firmware-mode flag |
| taken | output | 1 | One-cycle entry pulse |
| takenCause | output | 4 | Cause code of the last entry |

## Verification
The assertions assume that the pipeline keeps all inputs steady across each rising edge, and that `fwBase` is set far enough below the top of the address space that adding an offset does not wrap. The bench changes every input one time unit after an edge and uses base addresses well clear of the top of the 64-bit range. It covers each priority level against each single source, mixed request sets, every valid and several invalid cause codes, and both halves of the firmware-call range.

// File: rtl/tvu_pkg.sv
package tvu_pkg;

  typedef enum logic [3:0] {
    C_RESET   = 4'd0,
    C_MCHK    = 4'd1,
    C_IPI     = 4'd2,
    C_CLK     = 4'd3,
    C_DEV     = 4'd4,
    C_MMFAULT = 4'd5,
    C_UNALIGN = 4'd6,
    C_OPCODE  = 4'd7,
    C_ARITH   = 4'd8,
    C_FPDIS   = 4'd9,
    C_CALL    = 4'd10
  } cause_e;

  localparam int CAUSE_W      = 4;
  localparam int NUM_IRQ      = 4;
  localparam int DEV_CEILING  = 3;
  localparam logic [CAUSE_W-1:0] LAST_CODE = 4'd10;

  localparam int CALL_W          = 8;
  localparam int VEC_SHIFT       = 7;
  localparam int CALL_SHIFT      = 6;
  localparam int CALL_PRIV_BASE  = 'h1000;
  localparam int CALL_USER_BASE  = 'h2000;
  localparam int OFS_W           = 14;

  typedef struct packed {
    logic   take;
    cause_e cause;
  } ctrl_strobe_t;

endpackage

// File: rtl/tvu_arbiter.sv
module tvu_arbiter
  import tvu_pkg::*;
#(
  parameter int IPL_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_IRQ-1:0]  irqVec,
  input  logic [IPL_W-1:0]    ipl,
  input  logic                excReq,
  input  logic [CAUSE_W-1:0]  excCode,
  input  logic                fwMode,
  output ctrl_strobe_t        strb
);

  localparam int IDX_W = $clog2(NUM_IRQ);

  logic [NUM_IRQ-1:0] eligible;
  logic [IDX_W-1:0]   winIdx;
  logic               anyElig;
  logic               excValid;

  // Source i (0 dev, 1 clk, 2 ipi, 3 mchk) may fire up to level DEV_CEILING+i
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_mask
    localparam logic [IPL_W-1:0] CEIL = IPL_W'(DEV_CEILING + i);
    assign eligible[i] = irqVec[i] && (ipl <= CEIL);
  end

  // Higher index overrides lower: machine check ends on top
  always_comb begin
    winIdx  = '0;
    anyElig = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (eligible[i]) begin
        winIdx  = IDX_W'(i);
        anyElig = 1'b1;
      end
    end
  end

  assign excValid = excReq && (excCode <= LAST_CODE);

  always_comb begin
    strb.take  = 1'b0;
    strb.cause = C_RESET;
    if (excValid) begin
      strb.take  = 1'b1;
      strb.cause = cause_e'(excCode);
    end else if (!fwMode && anyElig) begin
      strb.take  = 1'b1;
      strb.cause = cause_e'(CAUSE_W'(C_DEV) - CAUSE_W'(winIdx));
    end
  end

  AST_TOP_LEVEL_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    (ipl == '1 && !excReq) |-> !strb.take);  // R2

  AST_MCHK_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (irqVec[NUM_IRQ-1] && ipl != '1 && !fwMode && !excReq)
      |-> (strb.take && strb.cause == C_MCHK));  // R3

  AST_FW_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (fwMode && !excReq) |-> !strb.take);  // R4

  AST_BAD_CODE_NO_EXC: assert property (@(posedge clk) disable iff (!rstN)
    (excReq && excCode > LAST_CODE && (irqVec == '0)) |-> !strb.take);  // R11

endmodule

// File: rtl/tvu_datapath.sv
module tvu_datapath
  import tvu_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strb,
  input  logic [CALL_W-1:0]   callCode,
  input  logic [AW-1:0]       pc,
  input  logic [AW-1:0]       fwBase,
  input  logic                fwMode,
  output logic [AW-1:0]       newPc,
  output logic [AW-1:0]       savedPc,
  output logic                modeOut,
  output logic                taken,
  output logic [CAUSE_W-1:0]  takenCause
);

  localparam int SLOT_W = CALL_W - 1 + CALL_SHIFT;

  logic [OFS_W-1:0]  vecOfs;
  logic [SLOT_W-1:0] callSlot;

  assign callSlot = {callCode[CALL_W-2:0], {CALL_SHIFT{1'b0}}};

  always_comb begin
    if (strb.cause == C_CALL) begin
      if (callCode[CALL_W-1]) vecOfs = OFS_W'(CALL_USER_BASE) + OFS_W'(callSlot);
      else                    vecOfs = OFS_W'(CALL_PRIV_BASE) + OFS_W'(callSlot);
    end else begin
      vecOfs = OFS_W'({strb.cause, {VEC_SHIFT{1'b0}}});
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newPc      <= '0;
      savedPc    <= '0;
      modeOut    <= 1'b0;
      taken      <= 1'b0;
      takenCause <= '0;
    end else begin
      taken <= strb.take;
      if (strb.take) begin
        newPc      <= fwBase + AW'(vecOfs);
        savedPc    <= {pc[AW-1:1], fwMode};
        modeOut    <= 1'b1;
        takenCause <= strb.cause;
      end else begin
        modeOut    <= fwMode;
      end
    end
  end

  AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> (((newPc - $past(fwBase)) & AW'(6'h3f)) == '0));  // R6

  AST_SAVED_MODE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> (savedPc[0] == $past(fwMode)));  // R8

  AST_ENTRY_RAISES_MODE: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> (taken && modeOut));  // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.take |=> (!taken && $stable(newPc) && $stable(savedPc)));  // R10

endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import tvu_pkg::*;
#(
  parameter int AW    = 64,
  parameter int IPL_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               irqDev,
  input  logic               irqClk,
  input  logic               irqIpi,
  input  logic               irqMchk,
  input  logic [IPL_W-1:0]   ipl,
  input  logic               excReq,
  input  logic [3:0]         excCode,
  input  logic [7:0]         callCode,
  input  logic [AW-1:0]      pc,
  input  logic [AW-1:0]      fwBase,
  input  logic               fwMode,
  output logic [AW-1:0]      newPc,
  output logic [AW-1:0]      savedPc,
  output logic               modeOut,
  output logic               taken,
  output logic [3:0]         takenCause
);

  ctrl_strobe_t strb;

  tvu_arbiter #(.IPL_W(IPL_W)) arb_i (
    .clk     (clk),
    .rstN    (rstN),
    .irqVec  ({irqMchk, irqIpi, irqClk, irqDev}),
    .ipl     (ipl),
    .excReq  (excReq),
    .excCode (excCode),
    .fwMode  (fwMode),
    .strb    (strb)
  );

  tvu_datapath #(.AW(AW)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .callCode   (callCode),
    .pc         (pc),
    .fwBase     (fwBase),
    .fwMode     (fwMode),
    .newPc      (newPc),
    .savedPc    (savedPc),
    .modeOut    (modeOut),
    .taken      (taken),
    .takenCause (takenCause)
  );

endmodule

// File: tb/trap_vector_unit_tb.sv
module trap_vector_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqDev = 0, irqClk = 0, irqIpi = 0, irqMchk = 0;
  logic [2:0]  ipl = '0;
  logic        excReq = 0;
  logic [3:0]  excCode = '0;
  logic [7:0]  callCode = '0;
  logic [63:0] pc = '0, fwBase = '0;
  logic        fwMode = 0;
  logic [63:0] newPc, savedPc;
  logic        modeOut, taken;
  logic [3:0]  takenCause;

  int total = 0;
  int bad = 0;
  logic [63:0] lastNew = '0, lastSaved = '0;
  logic [3:0]  lastCause = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_vector_unit dut_i (
    .clk(clk), .rstN(rstN), .irqDev(irqDev), .irqClk(irqClk), .irqIpi(irqIpi),
    .irqMchk(irqMchk), .ipl(ipl), .excReq(excReq), .excCode(excCode),
    .callCode(callCode), .pc(pc), .fwBase(fwBase), .fwMode(fwMode),
    .newPc(newPc), .savedPc(savedPc), .modeOut(modeOut), .taken(taken),
    .takenCause(takenCause)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected cause from the requirements, -1 for no entry
  function automatic int expCause();
    if (excReq && excCode <= 4'd10) return int'(excCode);       // R5, R11
    if (fwMode) return -1;                                       // R4
    if (irqMchk && ipl <= 3'd6) return 1;                        // R2, R3
    if (irqIpi  && ipl <= 3'd5) return 2;
    if (irqClk  && ipl <= 3'd4) return 3;
    if (irqDev  && ipl <= 3'd3) return 4;
    return -1;
  endfunction

  function automatic logic [63:0] expOffset(int c);
    if (c == 10) begin                                           // R7
      if (callCode[7]) return 64'h2000 + 64'(callCode - 8'h80) * 64;
      return 64'h1000 + 64'(callCode) * 64;
    end
    return 64'(c) * 64'h80;                                      // R6
  endfunction

  // Apply the current inputs across one edge and check every output
  task automatic stepCheck(string tag);
    int c;
    logic [63:0] eNew, eSaved;
    logic eMode;
    c = expCause();
    if (c >= 0) begin
      eNew   = fwBase + expOffset(c);
      eSaved = {pc[63:1], fwMode};
      eMode  = 1'b1;
      lastCause = 4'(c);
    end else begin
      eNew   = lastNew;
      eSaved = lastSaved;
      eMode  = fwMode;
    end
    @(posedge clk); #1;
    chk({tag, " R10 taken"}, 64'(taken), 64'(c >= 0));
    chk({tag, " R3 cause"}, 64'(takenCause), 64'(lastCause));
    chk({tag, " R9 newPc"}, newPc, eNew);
    chk({tag, " R8 savedPc"}, savedPc, eSaved);
    chk({tag, " R9 modeOut"}, 64'(modeOut), 64'(eMode));
    lastNew = eNew;
    lastSaved = eSaved;
  endtask

  task automatic clearIn();
    {irqDev, irqClk, irqIpi, irqMchk} = '0;
    excReq = 0; excCode = '0; callCode = '0; ipl = '0; fwMode = 0;
  endtask

  task automatic tReset();
    chk("R1 taken", 64'(taken), 0);
    chk("R1 cause", 64'(takenCause), 0);
    chk("R1 newPc", newPc, 0);
    chk("R1 savedPc", savedPc, 0);
    chk("R1 modeOut", 64'(modeOut), 0);
  endtask

  task automatic tIplMatrix();
    fwBase = 64'h0000_4000_0000_0000; pc = 64'h1234_5678;
    for (int lvl = 0; lvl < 8; lvl++) begin
      for (int s = 0; s < 4; s++) begin
        clearIn();
        ipl = 3'(lvl);
        {irqMchk, irqIpi, irqClk, irqDev} = 4'(1 << s);
        stepCheck($sformatf("R2 ipl=%0d src=%0d", lvl, s));
        clearIn();
        stepCheck("R10 drop");
      end
    end
  endtask

  task automatic tPriority();
    fwBase = 64'h0000_0000_0010_0000; pc = 64'hABC0;
    clearIn(); {irqMchk, irqIpi, irqClk, irqDev} = 4'b1111;
    stepCheck("R3 all");
    irqMchk = 0; stepCheck("R3 no mchk");
    irqIpi = 0;  stepCheck("R3 clk over dev");
    irqClk = 0;  stepCheck("R3 dev only");
    clearIn(); ipl = 3'd5; {irqIpi, irqClk, irqDev} = 3'b111;
    stepCheck("R3 ipl5 mix");
    clearIn(); ipl = 3'd4; {irqClk, irqDev} = 2'b11;
    stepCheck("R3 ipl4 clk");
    clearIn(); stepCheck("R10 idle");
  endtask

  task automatic tFwBlock();
    clearIn(); fwMode = 1; {irqMchk, irqIpi, irqClk, irqDev} = 4'b1111;
    pc = 64'h8000_0010;
    stepCheck("R4 blocked");
    excReq = 1; excCode = 4'd8;
    stepCheck("R4 exc in fw");
    clearIn(); stepCheck("R4 idle");
  endtask

  task automatic tExcPrecedence();
    clearIn(); {irqMchk, irqIpi, irqClk, irqDev} = 4'b1111;
    excReq = 1; excCode = 4'd6; pc = 64'h0000_0000_0040_0104;
    stepCheck("R5 exc wins");
    excCode = 4'd0; stepCheck("R5 reset code wins");
    clearIn(); stepCheck("R5 idle");
  endtask

  task automatic tVectors();
    fwBase = 64'h0000_0200_0000_0000;
    for (int code = 0; code < 10; code++) begin
      clearIn(); excReq = 1; excCode = 4'(code); pc = 64'h1000 + 64'(code * 4);
      stepCheck($sformatf("R6 code=%0d", code));
    end
    clearIn(); stepCheck("R6 idle");
  endtask

  task automatic tCalls();
    logic [7:0] codes [6] = '{8'h00, 8'h3F, 8'h7F, 8'h80, 8'h83, 8'hFF};
    fwBase = 64'h0000_0000_0F00_0000;
    foreach (codes[k]) begin
      clearIn(); excReq = 1; excCode = 4'd10; callCode = codes[k];
      stepCheck($sformatf("R7 call=%0h", codes[k]));
    end
    clearIn(); stepCheck("R7 idle");
  endtask

  task automatic tSavedAddr();
    clearIn(); excReq = 1; excCode = 4'd7; pc = 64'hFEDC_BA98_7654_3211; fwMode = 0;
    stepCheck("R8 odd pc, user");
    pc = 64'h0123_4567_89AB_CDE0; fwMode = 1;
    stepCheck("R8 even pc, fw");
    clearIn(); stepCheck("R8 idle");
  endtask

  task automatic tPulseHold();
    clearIn(); irqClk = 1; pc = 64'h5550;
    stepCheck("R10 pulse");
    clearIn(); fwMode = 1;
    stepCheck("R9 hold, mode follows 1");
    fwMode = 0;
    stepCheck("R9 hold, mode follows 0");
  endtask

  task automatic tBadCode();
    for (int code = 11; code < 16; code++) begin
      clearIn(); excReq = 1; excCode = 4'(code);
      stepCheck($sformatf("R11 code=%0d alone", code));
    end
    clearIn(); excReq = 1; excCode = 4'd13; irqDev = 1; pc = 64'h7770;
    stepCheck("R11 falls to dev");
    clearIn(); stepCheck("R11 idle");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished (all requirements)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    rstN = 1;
    tIplMatrix();
    tPriority();
    tFwBlock();
    tExcPrecedence();
    tVectors();
    tCalls();
    tSavedAddr();
    tPulseHold();
    tBadCode();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule